// File: doc/BRIEF.md
# Binary Tree Up/Down Route Unit

This block computes the output port for one packet header inside a switch of a binary tree or fat tree. Every header carries a source leaf address and a destination leaf address. Bit j of an address selects the child taken at tree level j+1 on the way down. The switch is told its own level, counted upward from the leaves, where 1 is the lowest switch row and `TREE_LEVELS` is the root.

The unit XORs the two addresses. The most significant set bit of the result, at position i, says that the packet has to climb i+1 levels to reach the common ancestor. A switch below that level sends the packet up. When several parent links exist, it picks one of them round-robin among those that are ready. A switch at or above that level sends the packet down to the child named by the destination bit for its level. A packet addressed to its own source goes to the local port.

A packet that would need to climb past the root is dropped and raises a one-cycle error flag. Each decision is registered one cycle after the header is accepted, and it is held until the consumer takes it.

Top module: `tree_route_unit`

## Requirements
- R1: When source and destination are equal, the registered decision selects only the local port, which is `out_sel` bit 0.
- R2: With i the position of the highest set bit of source XOR destination, a switch whose level is below i+1 and below `TREE_LEVELS` routes up, to one parent port. Parent p is `out_sel` bit 3+p.
- R3: A switch whose level is at least i+1 routes down. It selects child c = destination bit (level-1), which is `out_sel` bit 1+c.
- R4: Up routes take the first ready parent link, searching from a rotating pointer. After a pick, the pointer moves to the link after the one taken, and links that are not ready are skipped.
- R5: A header that needs to go up while no parent link is ready is not accepted: `hdr_ready` is low.
- R6: A header that needs to go up at a switch whose level is `TREE_LEVELS` or above is dropped. `route_err` is high for exactly the cycle after acceptance, and `out_valid` stays low.
- R7: The decision appears on `out_valid`/`out_sel` in the cycle after `hdr_valid && hdr_ready`. While `out_valid` is high and `out_ready` is low, the output stays stable and `hdr_ready` is low.
- R8: After reset, `out_valid` and `route_err` are low, `hdr_ready` is high, and the round-robin pointer starts at parent 0.
- R9: Whenever `out_valid` is high, exactly one bit of `out_sel` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_level | input | LVL_W | Level of this switch, with 1 as the lowest switch row |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle if valid |
| hdr_src | input | ADDR_W | Source leaf address |
| hdr_dst | input | ADDR_W | Destination leaf address |
| up_ready | input | UP_W | Per-parent-link ready |
| out_valid | output | 1 | Registered route decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_sel | output | 3+UP_W | One-hot port: bit 0 local, bits 1..2 children, bits 3.. parents |
| route_err | output | 1 | One-cycle pulse for a dropped header |

## Verification
The assertions watch every cycle for four things: that a held decision stays stable under backpressure, that a valid select is one-hot, that an error pulse never coincides with a valid output, and that an up route lands on a parent link that was ready when the header was accepted. Only the bench scenarios can show the rest. These are the actual choice of child or local port for given addresses and levels, the rotation order of the parent pointer, the refusal of an up route while every parent is busy, and the drop at the root.

// File: rtl/tru_pkg.sv
package tru_pkg;
    localparam int CHILD_N   = 2;
    localparam int LOCAL_BIT = 0;
    localparam int CHILD_LO  = 1;
    localparam int PARENT_LO = CHILD_LO + CHILD_N;

    typedef enum logic [1:0] {
        RK_LOCAL = 2'd0,
        RK_UP    = 2'd1,
        RK_DOWN  = 2'd2,
        RK_FAULT = 2'd3
    } route_kind_e;
endpackage

// File: rtl/tru_rel_addr.sv
module tru_rel_addr #(
    parameter int ADDR_W = 5,
    parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    output logic              same,
    output logic [LVL_W-1:0]  climb
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel   = src ^ dst;
        same  = (rel == '0);
        climb = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (rel[b]) climb = LVL_W'(b + 1);
        end
    end
endmodule

// File: rtl/tru_rr_pick.sv
module tru_rr_pick #(
    parameter int N     = 2,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            if (!any && req[c]) begin
                any  = 1'b1;
                pick = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
    import tru_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int TREE_LEVELS = 4,
    parameter int UP_W        = 2,
    parameter int LVL_W       = $clog2(ADDR_W + 1),
    parameter int NPORT       = PARENT_LO + UP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  sw_level,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [ADDR_W-1:0] hdr_src,
    input  logic [ADDR_W-1:0] hdr_dst,
    input  logic [UP_W-1:0]   up_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NPORT-1:0]  out_sel,
    output logic              route_err
);
    localparam int IDX_W = (UP_W > 1) ? $clog2(UP_W) : 1;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [NPORT-1:0] sel;
        logic [IDX_W-1:0] ptr;
    } state_t;

    state_t      st_d, st_q;
    logic        same;
    logic [LVL_W-1:0] climb;
    logic        any_up;
    logic [IDX_W-1:0] up_pick;
    route_kind_e kind;
    logic        child_bit;
    logic        accept;

    tru_rel_addr #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_rel (
        .src   (hdr_src),
        .dst   (hdr_dst),
        .same  (same),
        .climb (climb)
    );

    tru_rr_pick #(.N(UP_W), .IDX_W(IDX_W)) u_pick (
        .req  (up_ready),
        .ptr  (st_q.ptr),
        .any  (any_up),
        .pick (up_pick)
    );

    always_comb begin
        child_bit = 1'b0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (LVL_W'(b + 1) == sw_level) child_bit = hdr_dst[b];
        end

        if (same)
            kind = RK_LOCAL;
        else if (sw_level < climb)
            kind = (sw_level >= LVL_W'(TREE_LEVELS)) ? RK_FAULT : RK_UP;
        else
            kind = RK_DOWN;

        hdr_ready = (!st_q.vld || out_ready) && !(kind == RK_UP && !any_up);
        accept    = hdr_valid && hdr_ready;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (out_ready) st_d.vld = 1'b0;

        if (accept) begin
            st_d.sel = '0;
            st_d.vld = (kind != RK_FAULT);
            st_d.err = (kind == RK_FAULT);
            case (kind)
                RK_LOCAL: st_d.sel[LOCAL_BIT] = 1'b1;
                RK_DOWN:  st_d.sel[CHILD_LO + int'(child_bit)] = 1'b1;
                RK_UP: begin
                    st_d.sel[PARENT_LO + int'(up_pick)] = 1'b1;
                    st_d.ptr = (int'(up_pick) == UP_W - 1) ? '0 : up_pick + 1'b1;
                end
                default: st_d.sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sel   = st_q.sel;
    assign route_err = st_q.err;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sel))); // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !hdr_ready); // R7
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_sel) == 1)); // R9
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |-> !out_valid); // R6
    AST_UP_READY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == RK_UP) |=> ((out_sel[PARENT_LO +: UP_W] & $past(up_ready)) != '0)); // R4
endmodule

// File: tb/tree_route_unit_test.sv
module tree_route_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int LW = 3;
    localparam int UW = 2;
    localparam int NP = 5;
    localparam int NVEC = 14;

    // {src, dst, level, up_ready, expected sel, expected err}
    localparam logic [20:0] VEC [NVEC] = '{
        {5'd0,  5'd0,  3'd1, 2'b11, 5'b00001, 1'b0},  // R1 local
        {5'd0,  5'd1,  3'd1, 2'b11, 5'b00100, 1'b0},  // R3 child1
        {5'd0,  5'd2,  3'd1, 2'b11, 5'b01000, 1'b0},  // R2 R8 parent0 first
        {5'd0,  5'd2,  3'd2, 2'b11, 5'b00100, 1'b0},  // R3
        {5'd6,  5'd4,  3'd2, 2'b11, 5'b00010, 1'b0},  // R3 child0
        {5'd0,  5'd8,  3'd3, 2'b11, 5'b10000, 1'b0},  // R4 rotate to parent1
        {5'd0,  5'd8,  3'd4, 2'b11, 5'b00100, 1'b0},  // R3 at root
        {5'd0,  5'd16, 3'd4, 2'b11, 5'b00000, 1'b1},  // R6 drop
        {5'd3,  5'd1,  3'd1, 2'b10, 5'b10000, 1'b0},  // R4 skip busy
        {5'd5,  5'd4,  3'd1, 2'b11, 5'b00010, 1'b0},  // R3
        {5'd15, 5'd0,  3'd2, 2'b01, 5'b01000, 1'b0},  // R2
        {5'd15, 5'd0,  3'd4, 2'b11, 5'b00010, 1'b0},  // R3
        {5'd21, 5'd21, 3'd3, 2'b11, 5'b00001, 1'b0},  // R1
        {5'd0,  5'd31, 3'd3, 2'b01, 5'b01000, 1'b0}   // R4 wrap search
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LW-1:0] sw_level = 3'd1;
    logic hdr_valid = 1'b0;
    logic hdr_ready;
    logic [AW-1:0] hdr_src = '0, hdr_dst = '0;
    logic [UW-1:0] up_ready = '1;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [NP-1:0] out_sel;
    logic route_err;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tree_route_unit #(.ADDR_W(AW), .TREE_LEVELS(4), .UP_W(UW)) uut (
        .clk(clk), .rst_n(rst_n), .sw_level(sw_level), .hdr_valid(hdr_valid),
        .hdr_ready(hdr_ready), .hdr_src(hdr_src), .hdr_dst(hdr_dst),
        .up_ready(up_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_sel(out_sel), .route_err(route_err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 out_valid", out_valid, 0);
        check("R8 route_err", route_err, 0);
        check("R8 hdr_ready", hdr_ready, 1);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            hdr_src   = VEC[v][20:16];
            hdr_dst   = VEC[v][15:11];
            sw_level  = VEC[v][10:8];
            up_ready  = VEC[v][7:6];
            hdr_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            hdr_valid = 1'b0;
            check("R7 out_valid vec", out_valid, !VEC[v][0]);
            check("R6 route_err vec", route_err, VEC[v][0]);
            if (!VEC[v][0]) check("R1-3 out_sel vec", out_sel, VEC[v][5:1]);
            @(negedge clk);
            check("R6 err one cycle", route_err, 0);
        end
        // pointer now at parent 1

        // R7 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        up_ready = 2'b11;
        hdr_src = 5'd3; hdr_dst = 5'd3; sw_level = 3'd1;
        hdr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hdr_src = 5'd0; hdr_dst = 5'd1;
        #1;
        check("R7 held valid", out_valid, 1);
        check("R7 hdr_ready low when full", hdr_ready, 0);
        repeat (2) @(negedge clk);
        check("R7 held sel", out_sel, 5'b00001);
        out_ready = 1'b1;
        #1;
        check("R7 hdr_ready after drain", hdr_ready, 1);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R7 second decision", out_sel, 5'b00100);
        check("R7 second valid", out_valid, 1);

        // R5 no parent ready
        @(negedge clk);
        up_ready = 2'b00;
        hdr_src = 5'd0; hdr_dst = 5'd2; sw_level = 3'd1;
        hdr_valid = 1'b1;
        #1;
        check("R5 hdr_ready blocked", hdr_ready, 0);
        @(posedge clk);
        @(negedge clk);
        check("R5 not accepted", out_valid, 0);
        up_ready = 2'b10;
        #1;
        check("R5 hdr_ready released", hdr_ready, 1);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R4 parent1 from pointer", out_sel, 5'b10000);
        @(negedge clk);
        check("R9 idle", out_valid, 0);
        finish_run();
    end
endmodule